// File: doc/BRIEF.md
# Converter Mode and Compensation Register Bank with Calibration Lockout

This block holds the operating-mode word and the two inter-channel compensation words of a dual-channel data converter. The words are loaded through a decoded write port: a 3-bit address, a 12-bit data word and a one-cycle write strobe. That port stands in for the serial three-wire link, whose shifting is handled elsewhere. The block presents the effective mode settings and the compensation values to the converter datapath.

While an auto-calibration run is in progress, the block takes over the mode outputs. It drives decimation on, a 1:1 demultiplex ratio and straight binary output coding, whatever is stored. It also refuses every register write. Calibration is opened by a one-cycle start pulse and closed by a done input from the calibration engine. Once calibration closes, the stored user settings reach the outputs again with no need to rewrite them.

Compensation values reach the datapath only when the compensation-mode field selects manual operation. The gain value is also held back when only one channel is in use.

Top module: `conv_ctrl_bank`

## Requirements
- R1: After reset the mode word is 12'hC00 and both compensation words are zero. The outputs show decimation off, demux code 2'b00, binary coding, automatic compensation, offset and gain outputs zero, and busy low.
- R2: The mode word sits at address 3'b000. Bit 0 enables decimation. Bits 2:1 give the demux code, where 2'b00 means 1:1. Bit 3 selects Gray coding when 1 and binary when 0. Bits 11:10 hold the compensation mode. An accepted write shows on the outputs in the cycle after the strobe.
- R3: A start pulse while idle raises busy in the next cycle, even if done is high at the same time. Done while busy lowers busy in the next cycle. Start while busy and done while idle have no effect.
- R4: While busy is high, the outputs show decimation 1, demux 2'b00 and coding 0, regardless of the stored mode word.
- R5: A write whose strobe falls in a cycle with busy high changes none of the stored words.
- R6: Write gating follows the registered busy flag. A write in the same cycle as the start pulse that opens calibration is accepted. A write in the same cycle as the done that closes it is rejected.
- R7: The stored mode settings are back on the outputs in the cycle after busy falls.
- R8: The offset word sits at address 3'b010. It appears on the offset output only when mode bits 11:10 are 2'b00; otherwise the output is zero. The manual flag output is high exactly in that case.
- R9: The gain word sits at address 3'b011. It appears on the gain output only in manual mode with the single-channel input low; otherwise the output is zero.
- R10: Writes to any address other than 3'b000, 3'b010 and 3'b011 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 12 | Write data |
| calib_start_i | input | 1 | Calibration start pulse |
| calib_done_i | input | 1 | Calibration finished |
| single_chan_i | input | 1 | High when only one channel is used |
| calib_busy_o | output | 1 | Calibration in progress |
| decim_o | output | 1 | Effective decimation enable |
| demux_o | output | 2 | Effective demux code |
| gray_o | output | 1 | Effective output coding (1 = Gray) |
| comp_manual_o | output | 1 | Manual compensation selected |
| offset_o | output | 12 | Offset compensation to datapath |
| gain_o | output | 12 | Gain compensation to datapath |

## Verification
Two functions can land in the same cycle: a register write and a calibration edge. The write lockout and the busy transition can each claim a write strobe that arrives at the moment calibration opens or closes. The bench drives a strobe in the very cycle of the start pulse and expects it to be stored. It then drives another strobe together with done and expects that one to be discarded. Both outcomes are read after calibration through the offset output in manual mode. The bench also raises start and done together while idle and expects busy to rise.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int DATA_W = 12;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'b000;
    localparam logic [ADDR_W-1:0] ADDR_OFFS = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_GAIN = 3'b011;

    localparam int DECIM_BIT = 0;
    localparam int DEMUX_LSB = 1;
    localparam int DEMUX_W   = 2;
    localparam int CODE_BIT  = 3;
    localparam int CMODE_LSB = 10;
    localparam int CMODE_W   = 2;

    localparam logic [DATA_W-1:0]  MODE_RST     = 12'hC00;
    localparam logic [DEMUX_W-1:0] DEMUX_ONE    = '0;
    localparam logic [CMODE_W-1:0] CMODE_MANUAL = '0;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] offs;
        logic [DATA_W-1:0] gain;
    } regs_t;

    typedef struct packed {
        logic busy;
    } cal_state_t;

endpackage

// File: rtl/ccr_regbank.sv
module ccr_regbank
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              lock_i,
    output regs_t             regs_o
);

    regs_t regs_d, regs_q;
    logic  wr_ok;

    always_comb begin
        regs_d = regs_q;
        wr_ok  = wr_en_i && !lock_i;
        if (wr_ok) begin
            case (wr_addr_i)
                ADDR_MODE: regs_d.mode = wr_data_i;
                ADDR_OFFS: regs_d.offs = wr_data_i;
                ADDR_GAIN: regs_d.gain = wr_data_i;
                default:   regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mode <= MODE_RST;
            regs_q.offs <= '0;
            regs_q.gain <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/ccr_calseq.sv
module ccr_calseq
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o
);

    cal_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) st_d.busy = 1'b1;
        end else begin
            if (done_i) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/ccr_override.sv
module ccr_override
    import ccr_pkg::*;
(
    input  regs_t              regs_i,
    input  logic               busy_i,
    input  logic               single_chan_i,
    output logic               decim_o,
    output logic [DEMUX_W-1:0] demux_o,
    output logic               gray_o,
    output logic               manual_o,
    output logic [DATA_W-1:0]  offset_o,
    output logic [DATA_W-1:0]  gain_o
);

    logic unused_mode_bits;
    assign unused_mode_bits = ^regs_i.mode[CMODE_LSB-1:CODE_BIT+1];

    always_comb begin
        if (busy_i) begin
            decim_o = 1'b1;
            demux_o = DEMUX_ONE;
            gray_o  = 1'b0;
        end else begin
            decim_o = regs_i.mode[DECIM_BIT];
            demux_o = regs_i.mode[DEMUX_LSB +: DEMUX_W];
            gray_o  = regs_i.mode[CODE_BIT];
        end
        manual_o = (regs_i.mode[CMODE_LSB +: CMODE_W] == CMODE_MANUAL);
        offset_o = manual_o ? regs_i.offs : '0;
        gain_o   = (manual_o && !single_chan_i) ? regs_i.gain : '0;
    end

endmodule

// File: rtl/conv_ctrl_bank.sv
module conv_ctrl_bank
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [11:0]       wr_data_i,
    input  logic              calib_start_i,
    input  logic              calib_done_i,
    input  logic              single_chan_i,
    output logic              calib_busy_o,
    output logic              decim_o,
    output logic [1:0]        demux_o,
    output logic              gray_o,
    output logic              comp_manual_o,
    output logic [11:0]       offset_o,
    output logic [11:0]       gain_o
);

    regs_t regs_q;
    logic  busy_q;

    ccr_calseq u_calseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (calib_start_i),
        .done_i  (calib_done_i),
        .busy_o  (busy_q)
    );

    ccr_regbank u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lock_i    (busy_q),
        .regs_o    (regs_q)
    );

    ccr_override u_override (
        .regs_i        (regs_q),
        .busy_i        (busy_q),
        .single_chan_i (single_chan_i),
        .decim_o       (decim_o),
        .demux_o       (demux_o),
        .gray_o        (gray_o),
        .manual_o      (comp_manual_o),
        .offset_o      (offset_o),
        .gain_o        (gain_o)
    );

    assign calib_busy_o = busy_q;

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        calib_start_i,
    input logic        calib_done_i,
    input logic        single_chan_i,
    input logic        calib_busy_o,
    input logic        decim_o,
    input logic [1:0]  demux_o,
    input logic        gray_o,
    input logic [11:0] offset_o,
    input logic [11:0] gain_o,
    input regs_t       regs_q
);

    // R3: start while idle raises busy
    a_r3_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (calib_start_i && !calib_busy_o) |=> calib_busy_o);

    // R3: done while busy lowers busy
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (calib_busy_o && calib_done_i) |=> !calib_busy_o);

    // R4: forced modes during calibration
    a_r4_forced_modes: assert property (@(posedge clk) disable iff (!rst_n)
        calib_busy_o |-> (decim_o && demux_o == 2'b00 && !gray_o));

    // R5: stored words frozen while busy
    a_r5_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        calib_busy_o |=> ($stable(regs_q.mode) && $stable(regs_q.offs) && $stable(regs_q.gain)));

    // R7: stored settings back as soon as busy falls
    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(calib_busy_o) |-> (decim_o == regs_q.mode[DECIM_BIT]
                                 && demux_o == regs_q.mode[DEMUX_LSB +: DEMUX_W]
                                 && gray_o == regs_q.mode[CODE_BIT]));

    // R8: offset held at zero outside manual mode
    a_r8_auto_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mode[CMODE_LSB +: CMODE_W] != CMODE_MANUAL) |-> (offset_o == '0));

    // R9: gain held at zero in single-channel use
    a_r9_single_gain: assert property (@(posedge clk) disable iff (!rst_n)
        single_chan_i |-> (gain_o == '0));

endmodule

bind conv_ctrl_bank ccr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .calib_start_i (calib_start_i),
    .calib_done_i  (calib_done_i),
    .single_chan_i (single_chan_i),
    .calib_busy_o  (calib_busy_o),
    .decim_o       (decim_o),
    .demux_o       (demux_o),
    .gray_o        (gray_o),
    .offset_o      (offset_o),
    .gain_o        (gain_o),
    .regs_q        (regs_q)
);

// File: tb/conv_ctrl_bank_tb.sv
module conv_ctrl_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        cal_start = 1'b0;
    logic        cal_done = 1'b0;
    logic        single = 1'b0;
    logic        busy, decim, gray, manual;
    logic [1:0]  demux;
    logic [11:0] offs, gain;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    conv_ctrl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .calib_start_i(cal_start), .calib_done_i(cal_done),
        .single_chan_i(single), .calib_busy_o(busy), .decim_o(decim),
        .demux_o(demux), .gray_o(gray), .comp_manual_o(manual),
        .offset_o(offs), .gain_o(gain)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input int d, input int m, input int g);
        chk({req, " decim"}, int'(decim), d);
        chk({req, " demux"}, int'(demux), m);
        chk({req, " coding"}, int'(gray), g);
    endtask

    // drive for one cycle, starting at a falling edge
    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic pulse_done();
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk_mode("R1", 0, 0, 0);
        chk("R1 manual", int'(manual), 0);
        chk("R1 offset", int'(offs), 0);
        chk("R1 gain", int'(gain), 0);
    endtask

    task automatic t_mode_write();
        wr(3'b000, 12'h00D);
        chk_mode("R2", 1, 2, 1);
        chk("R2 manual", int'(manual), 1);
    endtask

    task automatic t_comp();
        wr(3'b010, 12'h5A3);
        wr(3'b011, 12'h1F0);
        chk("R8 offset manual", int'(offs), 'h5A3);
        chk("R9 gain dual", int'(gain), 'h1F0);
        single = 1'b1;
        @(negedge clk);
        chk("R9 gain single", int'(gain), 0);
        chk("R8 offset single", int'(offs), 'h5A3);
        single = 1'b0;
        wr(3'b000, 12'h80D);
        chk("R8 offset auto10", int'(offs), 0);
        chk("R8 manual auto10", int'(manual), 0);
        chk("R9 gain auto10", int'(gain), 0);
        wr(3'b000, 12'h40D);
        chk("R8 offset auto01", int'(offs), 0);
        wr(3'b000, 12'h00D);
        chk("R8 offset back", int'(offs), 'h5A3);
        chk("R9 gain back", int'(gain), 'h1F0);
    endtask

    task automatic t_unused();
        wr(3'b001, 12'hFFF);
        wr(3'b100, 12'hFFF);
        wr(3'b111, 12'h000);
        chk_mode("R10", 1, 2, 1);
        chk("R10 offset", int'(offs), 'h5A3);
        chk("R10 gain", int'(gain), 'h1F0);
    endtask

    task automatic t_calib();
        wr(3'b000, 12'h00E);
        chk_mode("R2 pre-cal", 0, 3, 1);
        pulse_start();
        chk("R3 busy set", int'(busy), 1);
        chk_mode("R4 forced", 1, 0, 0);
        wr(3'b000, 12'hC01);
        wr(3'b010, 12'h111);
        wr(3'b011, 12'h222);
        chk_mode("R4 forced after writes", 1, 0, 0);
        chk("R5 offset held", int'(offs), 'h5A3);
        // write alongside done: still locked
        cal_done = 1'b1; wr_en = 1'b1; wr_addr = 3'b010; wr_data = 12'h333;
        @(negedge clk);
        cal_done = 1'b0; wr_en = 1'b0;
        chk("R3 busy cleared", int'(busy), 0);
        chk_mode("R7 restored", 0, 3, 1);
        chk("R5 manual kept", int'(manual), 1);
        chk("R6 write with done rejected", int'(offs), 'h5A3);
        chk("R5 gain kept", int'(gain), 'h1F0);
    endtask

    task automatic t_write_with_start();
        cal_start = 1'b1; wr_en = 1'b1; wr_addr = 3'b010; wr_data = 12'h0AA;
        @(negedge clk);
        cal_start = 1'b0; wr_en = 1'b0;
        chk("R6 busy after start", int'(busy), 1);
        pulse_done();
        chk("R6 write with start accepted", int'(offs), 'h0AA);
    endtask

    task automatic t_edges();
        cal_start = 1'b1; cal_done = 1'b1;
        @(negedge clk);
        cal_start = 1'b0; cal_done = 1'b0;
        chk("R3 start beats done", int'(busy), 1);
        pulse_start();
        chk("R3 start while busy", int'(busy), 1);
        pulse_done();
        chk("R3 done clears", int'(busy), 0);
        pulse_done();
        chk("R3 done while idle", int'(busy), 0);
        chk_mode("R7 idle mode", 0, 3, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_write();
        t_comp();
        t_unused();
        t_calib();
        t_write_with_start();
        t_edges();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule